// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single inter-thread synchronisation cell that holds a 16-bit counting semaphore. Threads reach it through single-cycle requests. Each request carries a read/write flag, a 3-bit view code that selects how the access is interpreted, write data, and the requesting thread's ID. Through the P/V views a read takes one unit from the count and a write gives one unit back. A take may block or may poll.

A blocking take that finds the count at zero is refused in the same cycle by a stall response. The cell then records the requesting thread in a waiter mask. The next give broadcasts a one-cycle wake pulse with that mask, and the mask is cleared. Stalled threads are expected to retry once their ID appears in a wake. The cell also has a raw view that reads the count, a tag view that reads and writes three status flags, and two queue-style views. The queue-style views belong to FIFO cells and do nothing on a semaphore.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the flags T, E and F are 0, no wake is pending, and the waiter mask is empty.
- R2: A read with view 4 (blocking take) or view 5 (polling take) returns the count as it was before the access, zero-extended. When that value is non-zero the count is one lower from the next cycle on.
- R3: A view 4 read that finds the count at zero raises rsp_stall in the same cycle and leaves the count unchanged. The requester's bit (bit index = req_thread) is added to the waiter mask. rsp_stall is low for every other request.
- R4: A view 5 read that finds the count at zero returns 0, does not stall and leaves the count at 0.
- R5: A write with view 4 or 5 ignores its data and adds one to the count, except when the count is already 0xFFFF, in which case the count holds.
- R6: If the waiter mask is non-empty when a view 4 or 5 write is accepted, wake_valid is high in the following cycle only, with wake_mask equal to the recorded mask. The mask is then empty, so a later give produces no wake unless new waiters arrived.
- R7: A read with view 0 (raw) returns the count unchanged. A view 0 write has no effect.
- R8: Reads with view 2 or 3 (queue views) return 0. Reads and writes with these views leave the count, the flags and the waiter mask unchanged.
- R9: A read with view 1 (tag) returns E at bit 0, F at bit 1 and T at bit 16, with all other bits 0 (including the FIFO flag at bit 17). A view 1 write loads E, F and T from those same data bits and leaves the count unchanged.
- R10: Views 6 and 7 read as 0 and have no effect on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write (give / flag load), 0 = read |
| req_view | input | 3 | View code: 0 raw, 1 tag, 2/3 queue, 4 blocking P/V, 5 polling P/V |
| req_wdata | input | DATA_W | Write data (used only by the tag view) |
| req_thread | input | ID_W | ID of the requesting thread |
| rsp_rdata | output | DATA_W | Read data, valid in the request cycle |
| rsp_stall | output | 1 | Request refused this cycle (blocking take at zero) |
| wake_valid | output | 1 | One-cycle wake pulse following a give |
| wake_mask | output | NUM_THREADS | Threads to wake, valid with wake_valid |

## Verification
Read data and the stall flag are combinational from the present state. The bench therefore drives each request just after a falling edge and compares them a moment later, within the same cycle. Count changes and the wake pulse come from registers. The wake is checked one time step after the rising edge that accepts the give, and each count is observed through a later raw or take read. Random mixes of views, directions and thread IDs run against a bench model. Directed runs cover saturation at 0xFFFF, polling and blocking takes at zero, and multiple waiters released by a single give.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [2:0] {
        VIEW_RAW     = 3'd0,
        VIEW_TAG     = 3'd1,
        VIEW_Q_WAIT  = 3'd2,
        VIEW_Q_POLL  = 3'd3,
        VIEW_PV_WAIT = 3'd4,
        VIEW_PV_POLL = 3'd5
    } sem_view_e;

    // Tag word bit positions shared with FIFO-type cells.
    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_FIFO_BIT = 17;

    typedef struct packed {
        logic take_wait;
        logic take_poll;
        logic give;
        logic raw_rd;
        logic tag_rd;
        logic tag_wr;
    } sem_op_t;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic [2:0] view,
    output sem_op_t    op
);
    always_comb begin
        op = '0;
        if (valid) begin
            unique case (view)
                VIEW_RAW:     op.raw_rd    = !write;
                VIEW_TAG:     begin
                    op.tag_rd = !write;
                    op.tag_wr = write;
                end
                VIEW_PV_WAIT: begin
                    op.take_wait = !write;
                    op.give      = write;
                end
                VIEW_PV_POLL: begin
                    op.take_poll = !write;
                    op.give      = write;
                end
                default:      op = '0;
            endcase
        end
    end
endmodule

// File: rtl/sem_count_next.sv
module sem_count_next #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic             take_wait,
    input  logic             take_poll,
    input  logic             give,
    output logic [CNT_W-1:0] count_d,
    output logic             stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic is_zero;
    assign is_zero = (count_q == '0);

    always_comb begin
        count_d = count_q;
        stall   = 1'b0;
        if (take_wait || take_poll) begin
            if (!is_zero) begin
                count_d = count_q - 1'b1;
            end else begin
                stall = take_wait;
            end
        end else if (give && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end
endmodule

// File: rtl/sem_waiter_next.sv
module sem_waiter_next #(
    parameter int NUM_THREADS = 8,
    parameter int ID_W        = 3
) (
    input  logic [NUM_THREADS-1:0] waiters_q,
    input  logic                   stall,
    input  logic [ID_W-1:0]        thread,
    input  logic                   give,
    output logic [NUM_THREADS-1:0] waiters_d,
    output logic                   fire,
    output logic [NUM_THREADS-1:0] fire_mask
);
    localparam logic [NUM_THREADS-1:0] ONE = {{(NUM_THREADS-1){1'b0}}, 1'b1};

    always_comb begin
        waiters_d = waiters_q;
        fire      = 1'b0;
        fire_mask = '0;
        if (give) begin
            fire      = |waiters_q;
            fire_mask = waiters_q;
            waiters_d = '0;
        end else if (stall) begin
            waiters_d = waiters_q | (ONE << thread);
        end
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_THREADS = 8,
    parameter int ID_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [2:0]             req_view,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [ID_W-1:0]        req_thread,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_stall,
    output logic                   wake_valid,
    output logic [NUM_THREADS-1:0] wake_mask
);
    localparam int PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0]       count;
        logic                   tag_t;
        logic                   tag_e;
        logic                   tag_f;
        logic [NUM_THREADS-1:0] waiters;
        logic                   wake_v;
        logic [NUM_THREADS-1:0] wake_m;
    } state_t;

    state_t                 state_d, state_q;
    sem_op_t                op;
    logic [CNT_W-1:0]       count_nx;
    logic                   stall;
    logic [NUM_THREADS-1:0] waiters_nx;
    logic                   fire;
    logic [NUM_THREADS-1:0] fire_mask;
    logic                   unused_wdata;

    assign unused_wdata = ^req_wdata;

    sem_view_decode u_decode (
        .valid (req_valid),
        .write (req_write),
        .view  (req_view),
        .op    (op)
    );

    sem_count_next #(.CNT_W(CNT_W)) u_count (
        .count_q   (state_q.count),
        .take_wait (op.take_wait),
        .take_poll (op.take_poll),
        .give      (op.give),
        .count_d   (count_nx),
        .stall     (stall)
    );

    sem_waiter_next #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_waiters (
        .waiters_q (state_q.waiters),
        .stall     (stall),
        .thread    (req_thread),
        .give      (op.give),
        .waiters_d (waiters_nx),
        .fire      (fire),
        .fire_mask (fire_mask)
    );

    always_comb begin
        state_d         = state_q;
        state_d.count   = count_nx;
        state_d.waiters = waiters_nx;
        state_d.wake_v  = fire;
        state_d.wake_m  = fire ? fire_mask : '0;
        if (op.tag_wr) begin
            state_d.tag_e = req_wdata[TAG_E_BIT];
            state_d.tag_f = req_wdata[TAG_F_BIT];
            state_d.tag_t = req_wdata[TAG_T_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (op.raw_rd || op.take_wait || op.take_poll) begin
            rsp_rdata = {{PAD_W{1'b0}}, state_q.count};
        end else if (op.tag_rd) begin
            rsp_rdata[TAG_E_BIT]    = state_q.tag_e;
            rsp_rdata[TAG_F_BIT]    = state_q.tag_f;
            rsp_rdata[TAG_T_BIT]    = state_q.tag_t;
            rsp_rdata[TAG_FIFO_BIT] = 1'b0;
        end
    end

    assign rsp_stall  = stall;
    assign wake_valid = state_q.wake_v;
    assign wake_mask  = state_q.wake_m;

endmodule

// File: rtl/sem_cell_checker.sv
module sem_cell_checker
    import sem_cell_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_THREADS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [2:0]             req_view,
    input logic                   rsp_stall,
    input logic                   wake_valid,
    input logic [NUM_THREADS-1:0] wake_mask,
    input logic [CNT_W-1:0]       count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic is_pv;
    assign is_pv = (req_view == VIEW_PV_WAIT) || (req_view == VIEW_PV_POLL);

    // R2: a take on a non-zero count lowers it by one
    p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && is_pv && count != '0)
        |=> (count == $past(count) - 1'b1));

    // R3: stall only for a blocking take at zero
    p_stall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (req_valid && !req_write && req_view == VIEW_PV_WAIT && count == '0));

    // R5: give saturates at the top value
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && is_pv && count == CNT_MAX) |=> (count == CNT_MAX));

    // R6: wake only right after a give, one cycle long, never empty
    p_wake_after_give_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> $past(req_valid && req_write && is_pv));

    p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);

    p_wake_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0));

    // R7 / R8 / R10: raw, queue and unused views leave the count alone
    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_pv) |=> $stable(count));

endmodule

bind sem_cell sem_cell_checker #(.CNT_W(CNT_W), .NUM_THREADS(NUM_THREADS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_view   (req_view),
    .rsp_stall  (rsp_stall),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask),
    .count      (state_q.count)
);

// File: tb/sem_cell_tb.sv
module sem_cell_tb;
    localparam int CNT_W       = 16;
    localparam int DATA_W      = 32;
    localparam int NUM_THREADS = 8;
    localparam int ID_W        = 3;
    localparam int WATCHDOG    = 190000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [2:0]             req_view = '0;
    logic [DATA_W-1:0]      req_wdata = '0;
    logic [ID_W-1:0]        req_thread = '0;
    logic [DATA_W-1:0]      rsp_rdata;
    logic                   rsp_stall;
    logic                   wake_valid;
    logic [NUM_THREADS-1:0] wake_mask;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench model
    logic [CNT_W-1:0]       m_count;
    logic                   m_t, m_e, m_f;
    logic [NUM_THREADS-1:0] m_wait;

    always #5 clk = ~clk;

    sem_cell #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_THREADS(NUM_THREADS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_wdata(req_wdata), .req_thread(req_thread),
        .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    function automatic logic [DATA_W-1:0] exp_rdata(input logic wr, input logic [2:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        if (!wr) begin
            if (v == 3'd0 || v == 3'd4 || v == 3'd5) r = DATA_W'(m_count);
            else if (v == 3'd1) r = (DATA_W'(m_t) << 16) | (DATA_W'(m_f) << 1) | DATA_W'(m_e);
        end
        return r;
    endfunction

    function automatic logic exp_stall(input logic wr, input logic [2:0] v);
        return !wr && v == 3'd4 && m_count == '0;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic wr, input logic [2:0] v);
        if (v == 3'd0) return "R7";
        if (v == 3'd1) return "R9";
        if (v == 3'd2 || v == 3'd3) return "R8";
        if (v >= 3'd6) return "R10";
        if (wr) return "R5";
        if (m_count == '0) return (v == 3'd4) ? "R3" : "R4";
        return "R2";
    endfunction

    task automatic do_req(input logic wr, input logic [2:0] v, input logic [DATA_W-1:0] d,
                          input logic [ID_W-1:0] th);
        string tag;
        logic  ew;
        logic [NUM_THREADS-1:0] em;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_view = v; req_wdata = d; req_thread = th;
        #1;
        tag = req_of(wr, v);
        check(tag, "rdata", 64'(rsp_rdata), 64'(exp_rdata(wr, v)));
        check("R3", "stall", 64'(rsp_stall), 64'(exp_stall(wr, v)));
        // model update
        ew = 1'b0; em = '0;
        if (wr && (v == 3'd4 || v == 3'd5)) begin
            if (m_count != '1) m_count = m_count + 1'b1;
            ew = |m_wait; em = m_wait; m_wait = '0;
        end else if (!wr && (v == 3'd4 || v == 3'd5)) begin
            if (m_count != '0) m_count = m_count - 1'b1;
            else if (v == 3'd4) m_wait[th] = 1'b1;
        end else if (wr && v == 3'd1) begin
            m_e = d[0]; m_f = d[1]; m_t = d[16];
        end
        @(posedge clk);
        #1;
        check("R6", "wake_valid", 64'(wake_valid), 64'(ew));
        if (ew) check("R6", "wake_mask", 64'(wake_mask), 64'(em));
    endtask

    initial begin
        #(WATCHDOG * 10);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_count = '0; m_t = 0; m_e = 0; m_f = 0; m_wait = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "wake_valid", 64'(wake_valid), 64'd0);
        check("R1", "stall", 64'(rsp_stall), 64'd0);
        rst_n = 1'b1;
        do_req(1'b0, 3'd1, '0, '0);           // R1 tag word all zero
        do_req(1'b0, 3'd0, '0, '0);           // R1 count zero
        // R4: polling take at zero
        do_req(1'b0, 3'd5, '0, 3'd2);
        do_req(1'b0, 3'd0, '0, '0);
        // R3: blocking takes at zero from threads 1 and 6
        do_req(1'b0, 3'd4, '0, 3'd1);
        do_req(1'b0, 3'd4, '0, 3'd6);
        // R6: one give wakes both, second give wakes none
        do_req(1'b1, 3'd4, 32'hDEAD_BEEF, 3'd0);
        do_req(1'b1, 3'd5, 32'h0, 3'd0);
        do_req(1'b0, 3'd0, '0, '0);           // count 2 (R5 data ignored)
        // R7 / R8 / R10: no effect
        do_req(1'b1, 3'd0, 32'h1234, '0);
        do_req(1'b1, 3'd2, 32'h55, '0);
        do_req(1'b0, 3'd3, '0, '0);
        do_req(1'b1, 3'd7, 32'hFFFF_FFFF, '0);
        do_req(1'b0, 3'd6, '0, '0);
        do_req(1'b0, 3'd0, '0, '0);
        // R9: tag write and read back
        do_req(1'b1, 3'd1, 32'hFFFF_FFFF, '0);
        do_req(1'b0, 3'd1, '0, '0);
        do_req(1'b1, 3'd1, 32'h0001_0002, '0);
        do_req(1'b0, 3'd1, '0, '0);
        do_req(1'b0, 3'd0, '0, '0);
        // R2: takes down to zero
        do_req(1'b0, 3'd4, '0, 3'd3);
        do_req(1'b0, 3'd5, '0, 3'd3);
        do_req(1'b0, 3'd0, '0, '0);
        // R5: saturation at 0xFFFF
        for (int i = 0; i < 65536; i++) do_req(1'b1, 3'd5, '0, '0);
        do_req(1'b0, 3'd0, '0, '0);
        do_req(1'b1, 3'd4, '0, '0);
        do_req(1'b0, 3'd5, '0, '0);
        do_req(1'b0, 3'd0, '0, '0);
        // drain partly, then random mix
        for (int i = 0; i < 65533; i++) do_req(1'b0, 3'd5, '0, '0);
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] v;
            int sel;
            sel = int'($urandom_range(0, 9));
            v = (sel < 6) ? ((sel < 3) ? 3'd4 : 3'd5) : 3'($urandom_range(0, 7));
            do_req(1'($urandom_range(0, 1)), v, $urandom(), ID_W'($urandom_range(0, NUM_THREADS-1)));
        end
        @(negedge clk);
        req_valid = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule